// File: doc/BRIEF.md
# Floating-Point Status Register Exception Unit

This block owns the floating-point status word of a processor core. Each time the arithmetic datapath finishes an operation it presents five IEEE exception flags with a valid strobe. The block rewrites the current-exception field from those flags. It then compares the fresh flags against the trap-enable mask. If any enabled flag is set, it records the IEEE trap type and pulses a trap request. If not, it folds the flags into the sticky accrued field.

Software can overwrite the whole word through a write port, except for the version field. The version is never stored. It is a parameter value that is merged into the word only on the read port. The stored rounding-direction field is decoded all the time into a one-hot rounding-mode output that drives the datapath.

Top module: `fpsr_exc_unit`

## Requirements
- R1: After reset the stored word is zero. The read port then shows only the version value in bits 19:17, `trap_req` is 0, and `rnd_mode` is 4'b0001.
- R2: On a flag event (`flag_vld`=1 with `sw_wr`=0), bits 4:0 take the flags in the order invalid, overflow, underflow, divide-by-zero, inexact (bit 4 down to bit 0). The trap-type field in bits 16:14 is cleared unless R3 applies.
- R3: When the fresh flags AND the trap enables in bits 27:23 (same flag order) is nonzero, bits 16:14 become 3'b001. `trap_req` is then high for exactly the one cycle after the event.
- R4: A trapping event leaves the accrued field in bits 9:5 unchanged.
- R5: A non-trapping event ORs the flags into bits 9:5, keeping the same flag order.
- R6: A flag event with all five flags zero clears bits 4:0 and 16:14. It leaves bits 9:5 unchanged and raises no trap.
- R7: A flag event changes no bit outside fields 4:0, 9:5 and 16:14.
- R8: A software write stores every bit of `sw_wdata` except bits 19:17. Those bits always read as the parameter `VERSION`, ORed into the stored word.
- R9: Bits 31:30 decode onto `rnd_mode` as one-hot: 0 gives nearest-even (bit 0), 1 gives toward zero (bit 1), 2 gives toward plus infinity (bit 2), 3 gives toward minus infinity (bit 3). Any other value falls back to toward zero.
- R10: When `sw_wr` and `flag_vld` are both high in the same cycle, the write is stored, the flags are discarded and no trap is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| flag_vld | input | 1 | An arithmetic result's flags are valid this cycle |
| flags | input | 5 | Invalid, overflow, underflow, divide-by-zero, inexact (MSB to LSB) |
| sw_wr | input | 1 | Software write strobe |
| sw_wdata | input | 32 | Software write data |
| rd_data | output | 32 | Status word with the version field merged in |
| trap_req | output | 1 | One-cycle IEEE exception trap request |
| rnd_mode | output | 4 | One-hot rounding mode decoded from bits 31:30 |

## Verification
A software write and a flag event can land in the same cycle. In that case the write has to win, and a flag that would trap must raise no trap. The bench provokes this directly, with an enabled flag present alongside a write. Random stimulus also overlaps the two strobes often. Each result is judged by comparing the full read word and `trap_req` one cycle later against a bench model that applies the write-first rule.

// File: rtl/fpsr_pkg.sv
`timescale 1ns/1ps
package fpsr_pkg;
  localparam int FLG_W    = 5;
  localparam int CEXC_LSB = 0;
  localparam int AEXC_LSB = 5;
  localparam int FTT_LSB  = 14;
  localparam int FTT_W    = 3;
  localparam int VER_LSB  = 17;
  localparam int VER_W    = 3;
  localparam int TEM_LSB  = 23;
  localparam int RD_LSB   = 30;
  localparam int RD_W     = 2;
  localparam int RM_W     = 4;

  localparam logic [FTT_W-1:0] FTT_IEEE = 3'b001;

  typedef enum logic [RD_W-1:0] {
    RD_NEAREST = 2'd0,
    RD_ZERO    = 2'd1,
    RD_POS     = 2'd2,
    RD_NEG     = 2'd3
  } rd_e;

  localparam logic [RM_W-1:0] RM_NEAREST = 4'b0001;
  localparam logic [RM_W-1:0] RM_ZERO    = 4'b0010;
  localparam logic [RM_W-1:0] RM_POS     = 4'b0100;
  localparam logic [RM_W-1:0] RM_NEG     = 4'b1000;
endpackage

// File: rtl/fpsr_rst_sync.sv
`timescale 1ns/1ps
module fpsr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/fpsr_exc_update.sv
`timescale 1ns/1ps
module fpsr_exc_update
  import fpsr_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0]     cur,
  input  logic [FLG_W-1:0] flags,
  output logic [W-1:0]     nxt,
  output logic             take_trap
);
  logic [FLG_W-1:0] tem;
  logic [FLG_W-1:0] hit;

  assign tem = cur[TEM_LSB +: FLG_W];
  assign hit = flags & tem;

  always_comb begin
    nxt                         = cur;
    nxt[CEXC_LSB +: FLG_W]      = flags;
    nxt[FTT_LSB +: FTT_W]       = '0;
    take_trap                   = |hit;
    if (take_trap) begin
      nxt[FTT_LSB +: FTT_W]     = FTT_IEEE;
    end else begin
      nxt[AEXC_LSB +: FLG_W]    = cur[AEXC_LSB +: FLG_W] | flags;
    end
  end
endmodule

// File: rtl/fpsr_rnd_decode.sv
`timescale 1ns/1ps
module fpsr_rnd_decode
  import fpsr_pkg::*;
(
  input  logic [RD_W-1:0] rd_field,
  output logic [RM_W-1:0] rnd_mode
);
  always_comb begin
    unique case (rd_e'(rd_field))
      RD_NEAREST: rnd_mode = RM_NEAREST;
      RD_POS:     rnd_mode = RM_POS;
      RD_NEG:     rnd_mode = RM_NEG;
      default:    rnd_mode = RM_ZERO;
    endcase
  end
endmodule

// File: rtl/fpsr_state.sv
`timescale 1ns/1ps
module fpsr_state
  import fpsr_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sw_wr,
  input  logic [W-1:0] sw_wdata,
  input  logic         flag_vld,
  input  logic [W-1:0] upd_nxt,
  input  logic         upd_trap,
  output logic [W-1:0] fsr_q,
  output logic         trap_q
);
  localparam logic [W-1:0] VER_MASK =
    {{(W-VER_W){1'b0}}, {VER_W{1'b1}}} << VER_LSB;

  logic [W-1:0] fsr_d;
  logic         fsr_en;
  logic         trap_d;

  always_comb begin
    fsr_en = sw_wr | flag_vld;
    fsr_d  = fsr_q;
    trap_d = 1'b0;
    if (sw_wr) begin
      fsr_d = sw_wdata & ~VER_MASK;
    end else if (flag_vld) begin
      fsr_d  = upd_nxt;
      trap_d = upd_trap;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fsr_q  <= '0;
      trap_q <= 1'b0;
    end else begin
      if (fsr_en) fsr_q <= fsr_d;
      trap_q <= trap_d;
    end
  end
endmodule

// File: rtl/fpsr_exc_unit.sv
`timescale 1ns/1ps
module fpsr_exc_unit
  import fpsr_pkg::*;
#(
  parameter int               W       = 32,
  parameter logic [VER_W-1:0] VERSION = 3'd5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flag_vld,
  input  logic [FLG_W-1:0] flags,
  input  logic             sw_wr,
  input  logic [W-1:0]     sw_wdata,
  output logic [W-1:0]     rd_data,
  output logic             trap_req,
  output logic [RM_W-1:0]  rnd_mode
);
  localparam logic [W-1:0] VER_MASK =
    {{(W-VER_W){1'b0}}, {VER_W{1'b1}}} << VER_LSB;
  localparam logic [W-1:0] VER_BITS =
    {{(W-VER_W){1'b0}}, VERSION} << VER_LSB;

  logic         rst_sync_n;
  logic [W-1:0] fsr_q;
  logic [W-1:0] upd_nxt;
  logic         upd_trap;

  fpsr_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  fpsr_exc_update #(.W(W)) u_upd (
    .cur       (fsr_q),
    .flags     (flags),
    .nxt       (upd_nxt),
    .take_trap (upd_trap)
  );

  fpsr_state #(.W(W)) u_state (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .sw_wr    (sw_wr),
    .sw_wdata (sw_wdata),
    .flag_vld (flag_vld),
    .upd_nxt  (upd_nxt),
    .upd_trap (upd_trap),
    .fsr_q    (fsr_q),
    .trap_q   (trap_req)
  );

  fpsr_rnd_decode u_rnd (
    .rd_field (fsr_q[RD_LSB +: RD_W]),
    .rnd_mode (rnd_mode)
  );

  assign rd_data = fsr_q | VER_BITS;

  // Assertions next to the logic they guard
  p_cexc_load_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (flag_vld && !sw_wr) |=> (fsr_q[CEXC_LSB +: FLG_W] == $past(flags)));

  p_trap_cause_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    trap_req |-> ($past(flag_vld && !sw_wr) && fsr_q[FTT_LSB +: FTT_W] == FTT_IEEE));

  p_acc_hold_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    trap_req |-> $stable(fsr_q[AEXC_LSB +: FLG_W]));

  p_ver_field_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rd_data[VER_LSB +: VER_W] == VERSION);

  p_rnd_onehot_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $countones(rnd_mode) == 1);

  p_wr_wins_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    sw_wr |=> (!trap_req && fsr_q == ($past(sw_wdata) & ~VER_MASK)));
endmodule

// File: tb/fpsr_exc_unit_tb.sv
`timescale 1ns/1ps
module fpsr_exc_unit_tb;
  localparam logic [31:0] VERM = 32'h000E_0000;
  localparam logic [31:0] VERB = 32'h000A_0000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        flag_vld;
  logic [4:0]  flags;
  logic        sw_wr;
  logic [31:0] sw_wdata;
  logic [31:0] rd_data;
  logic        trap_req;
  logic [3:0]  rnd_mode;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  logic [31:0] mdl;

  always #5 clk = ~clk;

  fpsr_exc_unit #(.W(32), .VERSION(3'd5)) u_dut (
    .clk(clk), .rst_n(rst_n), .flag_vld(flag_vld), .flags(flags),
    .sw_wr(sw_wr), .sw_wdata(sw_wdata), .rd_data(rd_data),
    .trap_req(trap_req), .rnd_mode(rnd_mode)
  );

  function automatic logic [31:0] model_step(input logic [31:0] m, input logic vld,
      input logic [4:0] fl, input logic wr, input logic [31:0] wd, output logic trp);
    logic [31:0] r;
    r = m; trp = 1'b0;
    if (wr) r = wd & ~VERM;
    else if (vld) begin
      r[4:0] = fl;
      r[16:14] = 3'b000;
      if ((fl & m[27:23]) != 5'd0) begin
        trp = 1'b1;
        r[16:14] = 3'b001;
      end else r[9:5] = m[9:5] | fl;
    end
    return r;
  endfunction

  function automatic logic [3:0] model_rnd(input logic [1:0] rd);
    case (rd)
      2'd0:    return 4'b0001;
      2'd2:    return 4'b0100;
      2'd3:    return 4'b1000;
      default: return 4'b0010;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic vld, input logic [4:0] fl, input logic wr,
                       input logic [31:0] wd, input string req);
    logic trp;
    logic [31:0] e;
    flag_vld = vld; flags = fl; sw_wr = wr; sw_wdata = wd;
    e = model_step(mdl, vld, fl, wr, wd, trp);
    @(negedge clk);
    flag_vld = 1'b0; flags = '0; sw_wr = 1'b0; sw_wdata = '0;
    mdl = e;
    chk({req, " word"}, rd_data, mdl | VERB);
    chk({req, " trap"}, {31'd0, trap_req}, {31'd0, trp});
    chk({req, " rnd"},  {28'd0, rnd_mode}, {28'd0, model_rnd(mdl[31:30])});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    n_vec++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    rst_n = 1'b0; flag_vld = 1'b0; flags = '0; sw_wr = 1'b0; sw_wdata = '0;
    mdl = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 word", rd_data, VERB);
    chk("R1 trap", {31'd0, trap_req}, 32'd0);
    chk("R1 rnd", {28'd0, rnd_mode}, 32'd1);

    // R8 write all ones, version bits masked then merged
    apply(1'b0, 5'd0, 1'b1, 32'hFFFF_FFFF, "R8 all-ones");
    chk("R8 version", {29'd0, rd_data[19:17]}, 32'd5);
    apply(1'b0, 5'd0, 1'b1, 32'h0000_0000, "R8 zero");
    // R9 every rounding code
    for (int k = 0; k < 4; k++)
      apply(1'b0, 5'd0, 1'b1, {k[1:0], 30'h0}, "R9 decode");

    // R2/R5: traps disabled, flags accrue; R7 fields kept
    apply(1'b0, 5'd0, 1'b1, 32'hC000_3000, "R7 setup");
    apply(1'b1, 5'b10101, 1'b0, '0, "R2 R5 R7 accrue a");
    apply(1'b1, 5'b01010, 1'b0, '0, "R5 accrue b");
    // R6 zero flags
    apply(1'b1, 5'b00000, 1'b0, '0, "R6 zero flags");

    // R3/R4: enable underflow trap
    apply(1'b0, 5'd0, 1'b1, 32'h0200_0000, "R3 setup");
    apply(1'b1, 5'b00101, 1'b0, '0, "R3 R4 trap");
    apply(1'b0, 5'd0, 1'b0, '0, "R3 pulse ends");
    apply(1'b1, 5'b00001, 1'b0, '0, "R2 trap type cleared");
    // R10 write and enabled flag together
    apply(1'b1, 5'b00100, 1'b1, 32'h4200_0000, "R10 collide");

    for (int i = 0; i < 600; i++) begin
      logic v, w;
      logic [4:0] f;
      logic [31:0] d;
      v = ($urandom_range(0, 3) != 0);
      w = ($urandom_range(0, 4) == 0);
      f = 5'($urandom);
      d = $urandom;
      apply(v, f, w, d, "random R2 R3 R5 R10");
    end
    finish_run();
  end
endmodule